// File: doc/BRIEF.md
# Adaptive Row-Buffer Page Policy Unit

This unit sits beside the command buffer of a DRAM controller. It holds one record per bank: whether that bank has a row open, and which row it is. When a column command (read or write) leaves the buffer, the unit reports three things in the same cycle. The first is whether the command must carry auto-precharge. The second is whether an explicit PRECHARGE must come first. The third is whether an ACTIVATE must come first. One clock edge later it updates the record for that bank.

A two-bit mode selects the policy. Closed-page mode closes the row after every access. Open-page mode keeps the row open until a different row is wanted or the bank is due for refresh. Adaptive mode keeps the row open while the buffer still holds further accesses to it, and puts auto-precharge on the last of them. The buffer provides a per-bank "more hits waiting" vector for this purpose.

The unit also flags every bank that is due for refresh while a row is still open, so that the scheduler can close the bank first. The scheduler reports each explicit PRECHARGE back to the unit, which then marks the bank closed. Command timing is not modelled here.

Top module: `page_policy_ctrl`

## Requirements
- R1: With `mode` = 0 (closed page), every valid command has `cmd_autopre` = 1. Mode code 3 behaves exactly like mode 0.
- R2: With `mode` = 1 (open page), a valid command has `cmd_autopre` = 1 only when `refresh_due` is set for its bank; otherwise 0.
- R3: With `mode` = 2 (adaptive), a valid command has `cmd_autopre` = 1 when `hit_pending` is clear for its bank or `refresh_due` is set for its bank; otherwise 0.
- R4: For a valid command, the miss flags depend on the state of the bank. A closed bank gives `cmd_need_act` = 1 and `cmd_need_pre` = 0. An open bank with a matching row gives both flags 0. An open bank with a different row gives both flags 1. All three command outputs are 0 when `cmd_valid` is 0.
- R5: One cycle after a valid command, its bank's entry in `bank_open`/`open_rows` shows the command's row as open if `cmd_autopre` was 0, and shows the bank closed if it was 1.
- R6: Banks are independent. A command or precharge on one bank leaves the entries of all other banks unchanged, so up to 8 rows can be open at once.
- R7: `ref_pre_need[b]` is 1 in the same cycle exactly when `refresh_due[b]` is 1 and bank b is open.
- R8: A `pre_valid` pulse closes bank `pre_bank` one cycle later. If a valid command targets the same bank in the same cycle, the command's update takes precedence.
- R9: After reset, all banks are closed and every `open_rows` field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 closed, 1 open, 2 adaptive, 3 as closed |
| cmd_valid | input | 1 | A column command is issuing this cycle |
| cmd_bank | input | 3 | Bank of the issuing command |
| cmd_row | input | 16 | Row of the issuing command |
| hit_pending | input | 8 | Per bank: buffer holds further hits to the open row |
| refresh_due | input | 8 | Per bank: refresh is due |
| pre_valid | input | 1 | Explicit PRECHARGE issued this cycle |
| pre_bank | input | 3 | Bank of the explicit PRECHARGE |
| cmd_autopre | output | 1 | Issue the command with auto-precharge |
| cmd_need_pre | output | 1 | A PRECHARGE is required before the command |
| cmd_need_act | output | 1 | An ACTIVATE is required before the command |
| ref_pre_need | output | 8 | Per bank: open row must close before refresh |
| bank_open | output | 8 | Per bank: a row is open |
| open_rows | output | 128 | Open row of each bank, bank b at bits [16b+15:16b] |

## Verification
The command outputs and `ref_pre_need` are combinational, so they are due in the cycle the stimulus is applied. The bench drives inputs just after a falling edge and samples these outputs a little later, before the next rising edge. The open-row table is registered, so a command or precharge shows up there one rising edge later, and the bench reads it at the following falling edge. A reference model in the bench tracks every bank and compares the whole table after each step, so changes to banks that were not addressed are caught as well.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    PM_CLOSED   = 2'd0,
    PM_OPEN     = 2'd1,
    PM_ADAPTIVE = 2'd2,
    PM_RSVD     = 2'd3
  } page_mode_e;
endpackage

// File: rtl/ppc_bank_entry.sv
module ppc_bank_entry #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [ROW_W-1:0] set_row,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    row_en = set_en;
    if (set_en) begin
      open_d = 1'b1;
      row_d  = set_row;
    end else if (clr_en) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_d;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

  // R6: without an update of its own, an entry holds its state
  a_r6_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> ($stable(open_o) && $stable(row_o)));

  // R5: a set leaves the bank open with the requested row
  a_r5_set_opens: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (open_o && row_o == $past(set_row)));
endmodule

// File: rtl/ppc_decide.sv
module ppc_decide #(
  parameter int ROW_W = 16
) (
  input  ppc_pkg::page_mode_e mode,
  input  logic                valid,
  input  logic                hit_more,
  input  logic                ref_due,
  input  logic                is_open,
  input  logic [ROW_W-1:0]    cur_row,
  input  logic [ROW_W-1:0]    req_row,
  output logic                autopre,
  output logic                need_pre,
  output logic                need_act
);
  import ppc_pkg::*;

  logic row_match;
  logic close_after;

  assign row_match = is_open && (cur_row == req_row);

  always_comb begin
    unique case (mode)
      PM_OPEN:     close_after = ref_due;
      PM_ADAPTIVE: close_after = ref_due || !hit_more;
      default:     close_after = 1'b1;
    endcase
  end

  assign autopre  = valid && close_after;
  assign need_pre = valid && is_open && !row_match;
  assign need_act = valid && !row_match;
endmodule

// File: rtl/page_policy_ctrl.sv
module page_policy_ctrl #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode,
  input  logic                       cmd_valid,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_row,
  input  logic [NUM_BANKS-1:0]       hit_pending,
  input  logic [NUM_BANKS-1:0]       refresh_due,
  input  logic                       pre_valid,
  input  logic [BANK_W-1:0]          pre_bank,
  output logic                       cmd_autopre,
  output logic                       cmd_need_pre,
  output logic                       cmd_need_act,
  output logic [NUM_BANKS-1:0]       ref_pre_need,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
  import ppc_pkg::*;

  logic [ROW_W-1:0] row_tab [NUM_BANKS];
  logic [NUM_BANKS-1:0] set_vec, clr_vec;
  page_mode_e mode_e;

  assign mode_e = page_mode_e'(mode);

  ppc_decide #(.ROW_W(ROW_W)) u_decide (
    .mode     (mode_e),
    .valid    (cmd_valid),
    .hit_more (hit_pending[cmd_bank]),
    .ref_due  (refresh_due[cmd_bank]),
    .is_open  (bank_open[cmd_bank]),
    .cur_row  (row_tab[cmd_bank]),
    .req_row  (cmd_row),
    .autopre  (cmd_autopre),
    .need_pre (cmd_need_pre),
    .need_act (cmd_need_act)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic cmd_here, pre_here;
    assign cmd_here   = cmd_valid && (cmd_bank == BANK_W'(b));
    assign pre_here   = pre_valid && (pre_bank == BANK_W'(b));
    assign set_vec[b] = cmd_here && !cmd_autopre;
    assign clr_vec[b] = (cmd_here && cmd_autopre) || (pre_here && !cmd_here);

    ppc_bank_entry #(.ROW_W(ROW_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_vec[b]),
      .clr_en  (clr_vec[b]),
      .set_row (cmd_row),
      .open_o  (bank_open[b]),
      .row_o   (row_tab[b])
    );

    assign open_rows[b*ROW_W +: ROW_W] = row_tab[b];
  end

  assign ref_pre_need = refresh_due & bank_open;

  // R1: closed-page policy always closes after the access
  a_r1_closed_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (mode == 2'd0 || mode == 2'd3)) |-> cmd_autopre);

  // R5: an auto-precharged command leaves its bank closed
  a_r5_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_autopre) |=> !bank_open[$past(cmd_bank)]);

  // R4: a row conflict always needs a new activation as well
  a_r4_pre_implies_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_need_pre |-> cmd_need_act);

  // R4: no miss flags without a command
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !(cmd_autopre || cmd_need_pre || cmd_need_act));

  // R8: a lone precharge closes its bank
  a_r8_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && !(cmd_valid && cmd_bank == pre_bank)) |=> !bank_open[$past(pre_bank)]);

  // R6: at most one entry changes per cycle from a command, at most two overall
  a_r6_few_updates: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_vec | clr_vec) <= 2);
endmodule

// File: tb/page_policy_ctrl_tb.sv
module page_policy_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic cmd_valid;
  logic [2:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [NB-1:0] hit_pending, refresh_due;
  logic pre_valid;
  logic [2:0] pre_bank;
  logic cmd_autopre, cmd_need_pre, cmd_need_act;
  logic [NB-1:0] ref_pre_need, bank_open;
  logic [NB*RW-1:0] open_rows;

  int n_tests = 0;
  int n_fail  = 0;

  logic          m_open [NB];
  logic [RW-1:0] m_row  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_policy_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_valid(cmd_valid),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .hit_pending(hit_pending),
    .refresh_due(refresh_due), .pre_valid(pre_valid), .pre_bank(pre_bank),
    .cmd_autopre(cmd_autopre), .cmd_need_pre(cmd_need_pre),
    .cmd_need_act(cmd_need_act), .ref_pre_need(ref_pre_need),
    .bank_open(bank_open), .open_rows(open_rows)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_table(input string req);
    for (int b = 0; b < NB; b++) begin
      chk(req, $sformatf("open bank %0d", b), 32'(bank_open[b]), 32'(m_open[b]));
      if (m_open[b])
        chk(req, $sformatf("row bank %0d", b), 32'(open_rows[b*RW +: RW]), 32'(m_row[b]));
    end
  endtask

  task automatic idle();
    cmd_valid = 1'b0; pre_valid = 1'b0; hit_pending = '0; refresh_due = '0;
    cmd_bank = '0; cmd_row = '0; pre_bank = '0;
  endtask

  // one command: check combinational outputs, clock, check table
  task automatic do_cmd(input string req, input logic [1:0] md, input int bank,
                        input logic [RW-1:0] row, input logic hit, input logic rdue);
    logic e_ap, e_pre, e_act, hitrow;
    @(negedge clk);
    idle();
    mode = md; cmd_valid = 1'b1; cmd_bank = 3'(bank); cmd_row = row;
    hit_pending[bank] = hit; refresh_due[bank] = rdue;
    #1;
    if (md == 2'd1)      e_ap = rdue;
    else if (md == 2'd2) e_ap = rdue || !hit;
    else                 e_ap = 1'b1;
    hitrow = m_open[bank] && (m_row[bank] == row);
    e_pre  = m_open[bank] && !hitrow;
    e_act  = !hitrow;
    chk(req, "autopre", 32'(cmd_autopre), 32'(e_ap));
    chk("R4", "need_pre", 32'(cmd_need_pre), 32'(e_pre));
    chk("R4", "need_act", 32'(cmd_need_act), 32'(e_act));
    @(negedge clk);
    m_open[bank] = !e_ap;
    if (!e_ap) m_row[bank] = row;
    idle();
    #1;
    chk_table("R5");
  endtask

  task automatic t_reset();
    for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    chk("R9", "bank_open", 32'(bank_open), 32'h0);
    chk("R9", "open_rows zero", 32'(open_rows == '0), 32'h1);
  endtask

  task automatic t_closed();
    do_cmd("R1", 2'd0, 0, 16'h0011, 1'b1, 1'b0);
    do_cmd("R1", 2'd3, 1, 16'h0022, 1'b1, 1'b0);
  endtask

  task automatic t_open();
    do_cmd("R2", 2'd1, 2, 16'h1234, 1'b0, 1'b0);   // activate, stays open
    do_cmd("R2", 2'd1, 2, 16'h1234, 1'b0, 1'b0);   // row hit
    do_cmd("R2", 2'd1, 2, 16'h4321, 1'b0, 1'b0);   // conflict
    do_cmd("R2", 2'd1, 2, 16'h4321, 1'b1, 1'b1);   // refresh due closes
  endtask

  task automatic t_adaptive();
    do_cmd("R3", 2'd2, 3, 16'h00AA, 1'b1, 1'b0);   // more hits: keep
    do_cmd("R3", 2'd2, 3, 16'h00AA, 1'b1, 1'b0);
    do_cmd("R3", 2'd2, 3, 16'h00AA, 1'b0, 1'b0);   // last hit closes
    do_cmd("R3", 2'd2, 4, 16'h0BBB, 1'b1, 1'b1);   // refresh overrides hits
  endtask

  task automatic t_multi();
    // R6: eight rows open at once, independent
    for (int b = 0; b < NB; b++) do_cmd("R6", 2'd1, b, 16'(16'h100 + b), 1'b0, 1'b0);
    do_cmd("R6", 2'd2, 5, 16'h0105, 1'b0, 1'b0);
  endtask

  task automatic t_refresh_flag();
    @(negedge clk);
    idle();
    refresh_due = 8'hFF;
    #1;
    begin
      logic [NB-1:0] e;
      for (int b = 0; b < NB; b++) e[b] = m_open[b];
      chk("R7", "ref_pre_need", 32'(ref_pre_need), 32'(e));
    end
    refresh_due = 8'h0;
    #1;
    chk("R7", "ref_pre_need idle", 32'(ref_pre_need), 32'h0);
  endtask

  task automatic t_precharge();
    // lone precharge closes bank 0
    @(negedge clk);
    idle(); pre_valid = 1'b1; pre_bank = 3'd0;
    @(negedge clk);
    idle(); m_open[0] = 1'b0;
    #1; chk_table("R8");
    // same-cycle command on same bank wins
    @(negedge clk);
    idle(); mode = 2'd1; pre_valid = 1'b1; pre_bank = 3'd1;
    cmd_valid = 1'b1; cmd_bank = 3'd1; cmd_row = 16'h0777;
    @(negedge clk);
    idle(); m_open[1] = 1'b1; m_row[1] = 16'h0777;
    #1; chk_table("R8");
    // idle cycle: command outputs quiet
    chk("R4", "idle outputs", 32'({cmd_autopre, cmd_need_pre, cmd_need_act}), 32'h0);
  endtask

  initial begin
    idle(); mode = 2'd0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_closed();
    t_open();
    t_adaptive();
    t_multi();
    t_refresh_flag();
    t_precharge();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule